// File: doc/BRIEF.md
# Display RAM Processor Access Port with Read Prefetch

This block is the processor-facing half of a bit-mapped display memory holding 64 segment columns by 64 lines. The lines are grouped into 8 pages of 8, so one byte access reaches one column of one page. Bit 0 of the byte is the top line of the page and bit 7 is the bottom line. The block holds a 3-bit page register and a 6-bit column counter. The column counter advances by one after every data access and wraps from 63 to 0 without touching the page.

Reads go through a single-entry bus buffer. A read hands the processor whatever the buffer already holds, then refills the buffer from the current address. After any address load or any write, the first read is therefore a dummy read that returns stale data. A static mirror strap reverses the mapping from column address to physical segment. A separate combinational scan port reads single pixels by line and segment for the display side.

The buffer tracker is a two-state machine:
- `BUF_STALE` is entered at reset. Transition T_PRIME goes from `BUF_STALE` to `BUF_PRIMED` on an effective read.
- Transition T_INVAL goes from `BUF_PRIMED` back to `BUF_STALE` on a column load, a page load or an effective write.
- In all other cases the state holds.

Top module: `dram_port`

## Requirements
- R1: After reset the page register is 0, the column counter is 0, `dout` is 0x00, `dout_fresh` is 0 and the bus buffer holds 0x00.
- R2: An effective write stores `din` at the addressed page and segment on the clock edge where `wr_stb` is sampled high.
- R3: After each effective read or write the column counter advances by one. It wraps from 63 to 0, and the page register keeps its value.
- R4: `col_ld` loads `din[5:0]` into the column counter and `page_ld` loads `din[2:0]` into the page register. Neither load changes RAM contents. A load in the same cycle as a strobe suppresses that strobe, and a write in the same cycle as a read suppresses the read.
- R5: The first effective read after reset, after an address load or after a write returns the previous buffer content with `dout_fresh`=0.
- R6: Each effective read refills the buffer from the current address. A read that directly follows another read returns the byte at the column that the previous read addressed, with `dout_fresh`=1. `dout` changes only on an effective read.
- R7: With `mirror`=0, column c is stored at segment c. With `mirror`=1, column c is stored at segment 63-c. The strap is held static while accesses run.
- R8: Scan pixel (line L, segment s) is bit L mod 8 of the byte stored at page L/8, segment s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mirror | input | 1 | Column-to-segment reversal strap |
| col_ld | input | 1 | Load column counter from din[5:0] |
| page_ld | input | 1 | Load page register from din[2:0] |
| wr_stb | input | 1 | Data write strobe, one cycle per access |
| rd_stb | input | 1 | Data read strobe, one cycle per access |
| din | input | 8 | Write data or address load value |
| dout | output | 8 | Read data from the bus buffer |
| dout_fresh | output | 1 | 1 when the last read returned real data, 0 after a dummy read |
| scan_line | input | 6 | Scan-side line select |
| scan_seg | input | 6 | Scan-side segment select |
| scan_pixel | output | 1 | Selected pixel |

## Verification
Writes, loads and the column step all take effect on the edge that samples the strobe. The scan pixel is combinational, so it reflects a write right after that edge. `dout` and `dout_fresh` are registered on the edge of the read strobe. The bench drives every strobe on a falling edge, and it samples on the next falling edge, half a period after the edge that made the change. A bench model of the buffer and the column counter predicts each returned byte, including the dummy reads that follow loads, writes and reset.

// File: rtl/dram_pkg.sv
package dram_pkg;
    typedef enum logic {
        BUF_STALE  = 1'b0,
        BUF_PRIMED = 1'b1
    } buf_state_e;
endpackage

// File: rtl/dram_addr.sv
module dram_addr #(
    parameter int COL_W  = 6,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_ld,
    input  logic              page_ld,
    input  logic              step,
    input  logic [COL_W-1:0]  col_val,
    input  logic [PAGE_W-1:0] page_val,
    output logic [COL_W-1:0]  col,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col  <= '0;
            page <= '0;
        end else begin
            if (col_ld)
                col <= col_val;
            else if (step)
                col <= col + 1'b1;
            if (page_ld)
                page <= page_val;
        end
    end
endmodule

// File: rtl/dram_store.sv
module dram_store #(
    parameter int COL_W  = 6,
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [PAGE_W-1:0]       page,
    input  logic [COL_W-1:0]        seg,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic [PAGE_W+$clog2(DATA_W)-1:0] scan_line,
    input  logic [COL_W-1:0]        scan_seg,
    output logic                    scan_pixel
);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int LINE_W = PAGE_W + BIT_W;
    localparam int DEPTH  = (1 << PAGE_W) * (1 << COL_W);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] scan_byte;

    always_ff @(posedge clk) begin
        if (we)
            mem[{page, seg}] <= wdata;
    end

    always_comb begin
        rdata      = mem[{page, seg}];
        scan_byte  = mem[{scan_line[LINE_W-1:BIT_W], scan_seg}];
        scan_pixel = scan_byte[scan_line[BIT_W-1:0]];
    end
endmodule

// File: rtl/dram_rdbuf.sv
module dram_rdbuf
    import dram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              inval,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              fresh
);
    buf_state_e        state_q, state_d;
    logic [DATA_W-1:0] buf_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_STALE:  if (rd)    state_d = BUF_PRIMED;
            BUF_PRIMED: if (inval) state_d = BUF_STALE;
            default:               state_d = BUF_STALE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BUF_STALE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            dout  <= '0;
            fresh <= 1'b0;
        end else if (rd) begin
            dout  <= buf_q;
            buf_q <= rdata;
            fresh <= (state_q == BUF_PRIMED);
        end
    end
endmodule

// File: rtl/dram_port.sv
module dram_port #(
    parameter int COL_W  = 6,
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             mirror,
    input  logic                             col_ld,
    input  logic                             page_ld,
    input  logic                             wr_stb,
    input  logic                             rd_stb,
    input  logic [DATA_W-1:0]                din,
    output logic [DATA_W-1:0]                dout,
    output logic                             dout_fresh,
    input  logic [PAGE_W+$clog2(DATA_W)-1:0] scan_line,
    input  logic [COL_W-1:0]                 scan_seg,
    output logic                             scan_pixel
);
    logic              any_ld, do_wr, do_rd;
    logic [COL_W-1:0]  col_q, seg;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] rdata;

    assign any_ld = col_ld | page_ld;
    assign do_wr  = wr_stb & ~any_ld;
    assign do_rd  = rd_stb & ~wr_stb & ~any_ld;
    assign seg    = mirror ? ~col_q : col_q;

    dram_addr #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_ld  (col_ld),
        .page_ld (page_ld),
        .step    (do_wr | do_rd),
        .col_val (din[COL_W-1:0]),
        .page_val(din[PAGE_W-1:0]),
        .col     (col_q),
        .page    (page_q)
    );

    dram_store #(.COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .we        (do_wr),
        .page      (page_q),
        .seg       (seg),
        .wdata     (din),
        .rdata     (rdata),
        .scan_line (scan_line),
        .scan_seg  (scan_seg),
        .scan_pixel(scan_pixel)
    );

    dram_rdbuf #(.DATA_W(DATA_W)) u_rdbuf (
        .clk  (clk),
        .rst_n(rst_n),
        .rd   (do_rd),
        .inval(any_ld | do_wr),
        .rdata(rdata),
        .dout (dout),
        .fresh(dout_fresh)
    );
endmodule

// File: rtl/dram_port_chk.sv
module dram_port_chk #(
    parameter int COL_W  = 6,
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              col_ld,
    input logic              page_ld,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_fresh,
    input logic [COL_W-1:0]  col_q,
    input logic [PAGE_W-1:0] page_q
);
    logic rd_only, stepping;
    assign rd_only  = rd_stb & ~wr_stb & ~col_ld & ~page_ld;
    assign stepping = (rd_stb | wr_stb) & ~col_ld & ~page_ld;

    p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stepping |=> col_q == COL_W'($past(col_q) + 1'b1));

    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !page_ld |=> $stable(page_q));

    p_col_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_ld |=> col_q == $past(din[COL_W-1:0]));

    p_dummy_after_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_ld || page_ld || wr_stb) ##1 rd_only |=> !dout_fresh);

    p_fresh_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only ##1 rd_only |=> dout_fresh);

    p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_only |=> $stable(dout));
endmodule

bind dram_port dram_port_chk #(.COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_ld    (col_ld),
    .page_ld   (page_ld),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .din       (din),
    .dout      (dout),
    .dout_fresh(dout_fresh),
    .col_q     (col_q),
    .page_q    (page_q)
);

// File: tb/sim_dram_port.sv
module sim_dram_port;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mirror = 1'b0;
    logic       col_ld = 1'b0, page_ld = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_fresh;
    logic [5:0] scan_line = '0;
    logic [5:0] scan_seg = '0;
    logic       scan_pixel;

    int checks = 0;
    int errors = 0;

    logic [7:0] mmem [512];
    logic [7:0] mbuf;
    logic [5:0] mcol;
    logic [2:0] mpage;
    logic       mstale;

    dram_port u0 (
        .clk(clk), .rst_n(rst_n), .mirror(mirror), .col_ld(col_ld), .page_ld(page_ld),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout), .dout_fresh(dout_fresh),
        .scan_line(scan_line), .scan_seg(scan_seg), .scan_pixel(scan_pixel)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] segof(input logic [5:0] c);
        return mirror ? 6'd63 - c : c;
    endfunction

    task automatic ld_col(input logic [5:0] c);
        @(negedge clk); col_ld = 1'b1; din = {2'b00, c};
        @(negedge clk); col_ld = 1'b0;
        mcol = c; mstale = 1'b1;
    endtask

    task automatic ld_page(input logic [2:0] p);
        @(negedge clk); page_ld = 1'b1; din = {5'b0, p};
        @(negedge clk); page_ld = 1'b0;
        mpage = p; mstale = 1'b1;
    endtask

    task automatic do_wr(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; din = d;
        @(negedge clk); wr_stb = 1'b0;
        mmem[{mpage, segof(mcol)}] = d;
        mcol = mcol + 1'b1; mstale = 1'b1;
    endtask

    task automatic do_rd(input string req);
        logic [7:0] e;
        logic       ef;
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        e = mbuf; ef = !mstale;
        mbuf = mmem[{mpage, segof(mcol)}];
        mcol = mcol + 1'b1; mstale = 1'b0;
        chk(dout === e, req, dout, e);
        chk(dout_fresh === ef, req, dout_fresh, ef);
    endtask

    task automatic scan_chk(input logic [5:0] line, input logic [5:0] s, input string req);
        logic [7:0] b;
        scan_line = line; scan_seg = s; #1;
        b = mmem[{line[5:3], s}];
        chk(scan_pixel === b[line[2:0]], req, scan_pixel, b[line[2:0]]);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mmem[i] = 8'h00;
        mbuf = 8'h00; mcol = 0; mpage = 0; mstale = 1'b1;
        #(CLK_P * 3);
        @(negedge clk);
        // R1: reset state at the outputs
        chk(dout === 8'h00, "R1", dout, 0);
        chk(dout_fresh === 1'b0, "R1", dout_fresh, 0);
        rst_n = 1'b1;

        // R1/R5: first read after reset is dummy, returns reset buffer 0
        do_rd("R1");

        // R2/R3: fill every page; 64 writes from column 0 wrap back to column 0
        for (int p = 0; p < 8; p++) begin
            ld_page(3'(p));
            ld_col(6'd0);
            for (int c = 0; c < 64; c++) do_wr(8'((p * 37 + c * 5 + 1) & 255));
        end
        // R8/R2: exhaustive pixel sweep of the scan port
        for (int l = 0; l < 64; l++)
            for (int s = 0; s < 64; s++) scan_chk(6'(l), 6'(s), "R8");

        // R3/R5/R6: read sweep per page, starting mid-column, wrapping past 63
        for (int p = 0; p < 8; p++) begin
            ld_page(3'(p));
            ld_col(6'(p * 7));
            for (int k = 0; k < 66; k++) do_rd(k == 0 ? "R5" : "R6");
        end

        // R3: page kept after wrap; write at col 63 then col 0 of same page
        ld_page(3'd5);
        ld_col(6'd63);
        do_wr(8'h3C);
        do_wr(8'hC3);
        scan_chk(6'd40, 6'd63, "R3");
        scan_chk(6'd42, 6'd63, "R3");
        scan_chk(6'd40, 6'd0, "R3");
        scan_chk(6'd46, 6'd0, "R3");

        // R5: write then read is dummy
        ld_col(6'd10);
        do_rd("R5");
        do_rd("R6");
        do_wr(8'h77);
        do_rd("R5");
        do_rd("R6");

        // R4: loads leave RAM untouched
        ld_col(6'd21);
        ld_page(3'd2);
        for (int l = 16; l < 24; l++) scan_chk(6'(l), 6'd21, "R4");
        for (int l = 40; l < 48; l++) scan_chk(6'(l), 6'd63, "R4");
        do_rd("R4");
        do_rd("R4");

        // R7: mirror strap reverses column-to-segment mapping
        @(negedge clk); mirror = 1'b1;
        ld_page(3'd3);
        ld_col(6'd0);
        do_wr(8'hA5);
        ld_col(6'd63);
        do_wr(8'h5A);
        for (int l = 24; l < 32; l++) begin
            scan_chk(6'(l), 6'd63, "R7");
            scan_chk(6'(l), 6'd0, "R7");
        end
        chk(mmem[{3'd3, 6'd63}] == 8'hA5, "R7", mmem[{3'd3, 6'd63}], 8'hA5);
        ld_col(6'd62);
        for (int k = 0; k < 5; k++) do_rd("R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule